// File: doc/BRIEF.md
# Timer Compare and Capture Event Manager

This block generates timed output events and timestamps input events for a control-oriented processor. Two free-running 16-bit timers each count from zero up to their own programmable period and then restart at zero. Six compare channels each watch one of the timers. When a channel's active compare value equals the count, the channel's 2-bit action code decides what happens to its output pin. Each channel can therefore serve as an independent PWM output. Software writes a shadow compare value, and the active value picks it up only when the chosen timer wraps. This keeps a waveform free of glitches when its duty cycle changes in the middle of a period.

Four capture channels watch input pins. Each input passes through a two-flip-flop synchronizer and then an edge detector. When the selected edge is detected, the count of the chosen timer is pushed into that channel's own four-entry FIFO. The FIFO is governed by a small state machine with three states: EMPTY, PARTIAL and FULL. The transitions are:
- EMPTY goes to PARTIAL on an accepted push.
- PARTIAL goes to FULL on a push alone that fills the last slot.
- PARTIAL goes to EMPTY on a pop alone that takes the last entry.
- FULL goes to PARTIAL on a pop.
- Every other combination holds the state.

A push that arrives while the FIFO is FULL is dropped and sets a sticky overflow bit.

All registers are reached through a plain write port and a read port. Read data is registered, and a read of a FIFO address pops that FIFO.

Top module: `em_event_mgr`

## Requirements
- R1: Each timer count advances by one every clock. In a cycle where the count equals its period register, the next count is 0. The period registers are at addresses 0 (timer 0) and 1 (timer 1), reset to 0xFFFF, and a write takes effect at once.
- R2: A compare channel's control register is at address 8+c. Its bits [1:0] hold the action code and bit [2] selects the timer. In a cycle where the selected count equals the channel's active compare value, the pin is updated at the next clock edge by the action code: 00 holds, 01 sets to 1, 10 clears to 0, 11 inverts.
- R3: In a cycle without a match, the compare pin keeps its value.
- R4: Writes to address 2+c change only the shadow compare value, and reads of 2+c return it. The active value takes the shadow value at the clock edge that ends a cycle in which the selected timer equals its period.
- R5: The six compare channels operate independently of each other. Each has its own value, action and timer selection.
- R6: Capture control is at address 14. Channel k uses bits [3k+1:3k] as the edge select (00 off, 01 rising, 10 falling, 11 both) and bit [3k+2] to select the timer. The input passes through two synchronizing flip-flops. The pushed sample is the selected timer's count in the cycle between the second and third rising clock edges after the pin changes.
- R7: Each capture channel has a four-entry FIFO. A read request at address 16+k returns the oldest sample on rd_data one cycle later and removes it.
- R8: A detected edge while the FIFO is full is dropped and sets overflow bit k. The status register is at address 15: bits [3:0] are the overflow bits, bits [7:4] the empty flags and bits [11:8] the full flags. Writing a 1 to a bit in [3:0] clears that overflow bit, and a set in the same cycle wins.
- R9: A read of an empty FIFO returns 0 and leaves the FIFO contents unchanged.
- R10: When a read and a capture push reach one FIFO in the same cycle, the read is served from the contents before that cycle. The push is accepted unless the FIFO was already full before that cycle.
- R11: Addresses 24 and 25 return the current count of timer 0 and timer 1.
- R12: After reset, every count is 0, all pins are 0, all FIFOs are empty and all overflow bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe (pops a FIFO at 16..19) |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| cmp_out | output | 6 | Compare output pins |
| cap_in | input | 4 | Capture input pins |

## Verification
The hardest overlap is a capture push and a software pop landing on the same FIFO in the same cycle. When that happens, the result depends on which state the FIFO was in before the cycle. The bench raises a capture pin and then sweeps a FIFO read across several cycle offsets around the synchronized edge, both when the FIFO is empty and when it is full. A scoreboard model evaluates the pre-cycle state, queues the expected read value, overflow flags and empty flags, and compares them with what the design returns the next cycle. A second overlap, a shadow write in the cycle where the timer wraps, is checked against the pins every cycle.

// File: rtl/em_pkg.sv
package em_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        EDG_OFF  = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_BOTH = 2'b11
    } edge_e;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'b00,
        FS_PART  = 2'b01,
        FS_FULL  = 2'b10
    } fifo_st_e;

    localparam int A_PER  = 0;
    localparam int A_CMPV = 2;
    localparam int A_CMPC = 8;
    localparam int A_CAPC = 14;
    localparam int A_STAT = 15;
    localparam int A_FIFO = 16;
    localparam int A_CNT  = 24;
endpackage

// File: rtl/em_timer.sv
module em_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = (count == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= '1;
        end else if (per_we) begin
            period <= per_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wrap) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (count == $past(count) + 1'b1)); // R1
endmodule

// File: rtl/em_cmp_ch.sv
module em_cmp_ch
    import em_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_TIMERS = 2,
    parameter int TSW        = 1,
    localparam int CTL_W     = TSW + 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_all,
    input  logic [NUM_TIMERS-1:0]            wrap_all,
    input  logic                             sh_we,
    input  logic [CNT_W-1:0]                 sh_wdata,
    input  logic                             ctl_we,
    input  logic [CTL_W-1:0]                 ctl_wdata,
    output logic [CNT_W-1:0]                 shadow,
    output logic [CTL_W-1:0]                 ctl,
    output logic                             pin
);
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] sel_cnt;
    logic             sel_wrap;
    logic             match;
    logic             pin_nxt;
    act_e             act;

    assign act = act_e'(ctl[1:0]);

    always_comb begin
        sel_cnt  = '0;
        sel_wrap = 1'b0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (ctl[CTL_W-1:2] == TSW'(t)) begin
                sel_cnt  = cnt_all[t];
                sel_wrap = wrap_all[t];
            end
        end
    end

    assign match = (sel_cnt == active);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            ctl    <= '0;
        end else begin
            if (sh_we)  shadow <= sh_wdata;
            if (ctl_we) ctl    <= ctl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= '0;
        end else if (sel_wrap) begin
            active <= shadow;
        end
    end

    always_comb begin
        pin_nxt = pin;
        if (match) begin
            unique case (act)
                ACT_HOLD: pin_nxt = pin;
                ACT_SET:  pin_nxt = 1'b1;
                ACT_CLR:  pin_nxt = 1'b0;
                ACT_TGL:  pin_nxt = ~pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_nxt;
    end

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_SET) |=> pin); // R2
    AST_CLR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_CLR) |=> !pin); // R2
    AST_TGL_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_TGL) |=> (pin != $past(pin))); // R2
    AST_HOLD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(pin)); // R3
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wrap |=> (active == $past(shadow))); // R4
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wrap |=> $stable(active)); // R4
endmodule

// File: rtl/em_cap_ch.sv
module em_cap_ch
    import em_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DEPTH      = 4,
    parameter int NUM_TIMERS = 2,
    parameter int TSW        = 1,
    localparam int PW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pin_in,
    input  logic [1:0]                       mode,
    input  logic [TSW-1:0]                   tsel,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_all,
    input  logic                             pop,
    input  logic                             ovf_clr,
    output logic [CNT_W-1:0]                 rd_val,
    output logic                             empty,
    output logic                             full,
    output logic                             ovf
);
    logic             s1, s2, s3;
    logic             rise, fall, push;
    logic             push_ok, pop_ok;
    logic [CNT_W-1:0] sel_cnt;
    logic [CNT_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    fifo_st_e         state, state_nxt;
    edge_e            edg;

    assign edg = edge_e'(mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;

    always_comb begin
        unique case (edg)
            EDG_OFF:  push = 1'b0;
            EDG_RISE: push = rise;
            EDG_FALL: push = fall;
            EDG_BOTH: push = rise | fall;
        endcase
    end

    always_comb begin
        sel_cnt = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (tsel == TSW'(t)) sel_cnt = cnt_all[t];
        end
    end

    assign empty   = (state == FS_EMPTY);
    assign full    = (state == FS_FULL);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rd_val  = empty ? '0 : mem[rd_ptr];

    always_comb begin
        state_nxt = state;
        unique case (state)
            FS_EMPTY: if (push_ok) state_nxt = FS_PART;
            FS_PART: begin
                if (push_ok && !pop_ok && count == CW'(DEPTH - 1))
                    state_nxt = FS_FULL;
                else if (pop_ok && !push_ok && count == CW'(1))
                    state_nxt = FS_EMPTY;
            end
            FS_FULL:  if (pop_ok) state_nxt = FS_PART;
            default:  state_nxt = FS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= sel_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             ovf <= 1'b0;
        else if (push && full)  ovf <= 1'b1;
        else if (ovf_clr)       ovf <= 1'b0;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R8
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (empty && $stable(rd_ptr))); // R9
    AST_FULL_POP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push && full) |=> (count == CW'(DEPTH - 1))); // R10
endmodule

// File: rtl/em_event_mgr.sv
module em_event_mgr
    import em_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 16,
    parameter int NUM_CMP    = 6,
    parameter int NUM_CAP    = 4,
    parameter int CAP_DEPTH  = 4,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 16,
    localparam int TSW       = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
    localparam int CTL_W     = TSW + 2,
    localparam int CAPF_W    = TSW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_CMP-1:0] cmp_out,
    input  logic [NUM_CAP-1:0] cap_in
);
    logic [NUM_TIMERS-1:0][CNT_W-1:0] per_all, cnt_all;
    logic [NUM_TIMERS-1:0]            wrap_all;
    logic [NUM_CMP-1:0][CNT_W-1:0]    sh_all;
    logic [NUM_CMP-1:0][CTL_W-1:0]    cctl_all;
    logic [NUM_CAP*CAPF_W-1:0]        cap_ctl;
    logic [NUM_CAP-1:0][CNT_W-1:0]    cap_val;
    logic [NUM_CAP-1:0]               cap_empty, cap_full, cap_ovf;
    logic                             stat_we;
    logic [DATA_W-1:0]                rd_mux;

    assign stat_we = wr_en && (wr_addr == ADDR_W'(A_STAT));

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        em_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .per_we    (wr_en && (wr_addr == ADDR_W'(A_PER + t))),
            .per_wdata (wr_data[CNT_W-1:0]),
            .period    (per_all[t]),
            .count     (cnt_all[t]),
            .wrap      (wrap_all[t])
        );
    end

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        em_cmp_ch #(.CNT_W(CNT_W), .NUM_TIMERS(NUM_TIMERS), .TSW(TSW)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_all   (cnt_all),
            .wrap_all  (wrap_all),
            .sh_we     (wr_en && (wr_addr == ADDR_W'(A_CMPV + c))),
            .sh_wdata  (wr_data[CNT_W-1:0]),
            .ctl_we    (wr_en && (wr_addr == ADDR_W'(A_CMPC + c))),
            .ctl_wdata (wr_data[CTL_W-1:0]),
            .shadow    (sh_all[c]),
            .ctl       (cctl_all[c]),
            .pin       (cmp_out[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ctl <= '0;
        end else if (wr_en && (wr_addr == ADDR_W'(A_CAPC))) begin
            cap_ctl <= wr_data[NUM_CAP*CAPF_W-1:0];
        end
    end

    for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap
        em_cap_ch #(
            .CNT_W(CNT_W), .DEPTH(CAP_DEPTH), .NUM_TIMERS(NUM_TIMERS), .TSW(TSW)
        ) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_in  (cap_in[k]),
            .mode    (cap_ctl[k*CAPF_W +: 2]),
            .tsel    (cap_ctl[k*CAPF_W+2 +: TSW]),
            .cnt_all (cnt_all),
            .pop     (rd_en && (rd_addr == ADDR_W'(A_FIFO + k))),
            .ovf_clr (stat_we && wr_data[k]),
            .rd_val  (cap_val[k]),
            .empty   (cap_empty[k]),
            .full    (cap_full[k]),
            .ovf     (cap_ovf[k])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (rd_addr == ADDR_W'(A_PER + t)) rd_mux = DATA_W'(per_all[t]);
            if (rd_addr == ADDR_W'(A_CNT + t)) rd_mux = DATA_W'(cnt_all[t]);
        end
        for (int c = 0; c < NUM_CMP; c++) begin
            if (rd_addr == ADDR_W'(A_CMPV + c)) rd_mux = DATA_W'(sh_all[c]);
            if (rd_addr == ADDR_W'(A_CMPC + c)) rd_mux = DATA_W'(cctl_all[c]);
        end
        for (int k = 0; k < NUM_CAP; k++) begin
            if (rd_addr == ADDR_W'(A_FIFO + k)) rd_mux = DATA_W'(cap_val[k]);
        end
        if (rd_addr == ADDR_W'(A_CAPC)) rd_mux = DATA_W'(cap_ctl);
        if (rd_addr == ADDR_W'(A_STAT))
            rd_mux = DATA_W'({cap_full, cap_empty, cap_ovf});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R7
endmodule

// File: tb/em_event_mgr_tb.sv
module em_event_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [5:0]  cmp_out;
    logic [3:0]  cap_in = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    em_event_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .cmp_out(cmp_out), .cap_in(cap_in)
    );

    // ---------------- scoreboard model ----------------
    logic [15:0] m_per [2];
    logic [15:0] m_cnt [2];
    logic [15:0] m_sh  [6];
    logic [15:0] m_act [6];
    logic [1:0]  m_ac  [6];
    int          m_ts  [6];
    logic [5:0]  m_pin;
    logic [11:0] m_capc;
    logic [3:0]  m_s1, m_s2, m_s3, m_ovf;
    logic [15:0] m_q [4][$];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic        rd_pend = 1'b0;

    always @(posedge clk) begin : model
        logic [15:0] pc [2];
        logic        pw [2];
        logic [3:0]  fullp, emptp;
        logic [15:0] e;
        string       tg;
        int          pop_k;
        logic        r, f, psh;
        if (!rst_n) begin
            for (int t = 0; t < 2; t++) begin m_per[t] = 16'hFFFF; m_cnt[t] = 0; end
            for (int c = 0; c < 6; c++) begin
                m_sh[c] = 0; m_act[c] = 0; m_ac[c] = 0; m_ts[c] = 0;
            end
            m_pin = 0; m_capc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ovf = 0;
            for (int k = 0; k < 4; k++) m_q[k].delete();
            rd_pend = 1'b0;
        end else begin
            for (int t = 0; t < 2; t++) begin
                pc[t] = m_cnt[t]; pw[t] = (m_cnt[t] == m_per[t]);
            end
            for (int k = 0; k < 4; k++) begin
                fullp[k] = (m_q[k].size() == 4);
                emptp[k] = (m_q[k].size() == 0);
            end
            pop_k = -1;
            rd_pend = rd_en;
            if (rd_en) begin
                e = 0; tg = "other";
                if (rd_addr >= 16 && rd_addr < 20) begin
                    pop_k = int'(rd_addr) - 16;
                    if (!emptp[pop_k]) e = m_q[pop_k][0];
                    tg = "R6 R7 R9 R10 fifo";
                end else if (rd_addr == 15) begin
                    e = {4'b0, fullp, emptp, m_ovf};
                    tg = "R8 R9 R12 status";
                end else if (rd_addr == 24 || rd_addr == 25) begin
                    e = pc[rd_addr - 24];
                    tg = "R1 R11 count";
                end else if (rd_addr >= 2 && rd_addr < 8) begin
                    e = m_sh[rd_addr - 2];
                    tg = "R4 shadow";
                end
                exp_q.push_back(e);
                tag_q.push_back(tg);
            end
            if (wr_en && wr_addr == 15) m_ovf = m_ovf & ~wr_data[3:0];
            for (int k = 0; k < 4; k++) begin
                r = m_s2[k] & ~m_s3[k];
                f = ~m_s2[k] & m_s3[k];
                case (m_capc[3*k +: 2])
                    2'b01: psh = r;
                    2'b10: psh = f;
                    2'b11: psh = r | f;
                    default: psh = 1'b0;
                endcase
                if (pop_k == k && !emptp[k]) void'(m_q[k].pop_front());
                if (psh) begin
                    if (fullp[k]) m_ovf[k] = 1'b1;
                    else m_q[k].push_back(pc[m_capc[3*k+2]]);
                end
            end
            for (int c = 0; c < 6; c++) begin
                if (pc[m_ts[c]] == m_act[c]) begin
                    case (m_ac[c])
                        2'b01: m_pin[c] = 1'b1;
                        2'b10: m_pin[c] = 1'b0;
                        2'b11: m_pin[c] = ~m_pin[c];
                        default: ;
                    endcase
                end
                if (pw[m_ts[c]]) m_act[c] = m_sh[c];
            end
            if (wr_en) begin
                if (wr_addr < 2) m_per[wr_addr] = wr_data;
                if (wr_addr >= 2 && wr_addr < 8) m_sh[wr_addr - 2] = wr_data;
                if (wr_addr >= 8 && wr_addr < 14) begin
                    m_ac[wr_addr - 8] = wr_data[1:0];
                    m_ts[wr_addr - 8] = int'(wr_data[2]);
                end
                if (wr_addr == 14) m_capc = wr_data[11:0];
            end
            for (int t = 0; t < 2; t++) m_cnt[t] = pw[t] ? 16'd0 : pc[t] + 16'd1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
        end
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        logic [15:0] e;
        string       tg;
        if (rst_n) begin
            n_checks++;
            if (cmp_out !== m_pin) begin
                n_fail++;
                $display("FAIL R2 R3 R4 R5 pins: got %b expected %b", cmp_out, m_pin);
            end
            if (rd_pend && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                n_checks++;
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s read: got %h expected %h", tg, rd_data, e);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        done();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state at ports
        n_checks++;
        if (cmp_out !== 6'b0) begin
            n_fail++;
            $display("FAIL R12 pins after reset: got %b expected 000000", cmp_out);
        end
        rd(15);          // R12: status 0x00F0
        rd(24); rd(25);  // R11 counts

        // R1 periods, R2 R4 R5 compare setup
        wr(0, 16'd19);
        wr(1, 16'd9);
        wr(2, 16'd3);  wr(8,  16'b011);   // ch0 toggle, timer 0
        wr(3, 16'd0);  wr(9,  16'b001);   // ch1 set
        wr(4, 16'd10); wr(10, 16'b010);   // ch2 clear
        wr(5, 16'd4);  wr(11, 16'b111);   // ch3 toggle, timer 1
        wr(6, 16'd2);  wr(12, 16'b100);   // ch4 hold, timer 1
        wr(7, 16'd25); wr(13, 16'b001);   // ch5 never matches
        rd(2); rd(5);
        idle(60);
        rd(24); rd(25);
        // R4 shadow changes mid-period
        wr(3, 16'd12); wr(9, 16'b010);
        wr(4, 16'd5);  wr(10, 16'b001);
        idle(45);
        wr(2, 16'd19);                    // value equal to the period
        idle(45);

        // R6 capture setup: ch0 rise t0, ch1 fall t1, ch2 both t0, ch3 off
        wr(14, {3'b000, 3'b011, 3'b110, 3'b001});
        cap_in = 4'b0000; idle(5);
        cap_in = 4'b1111; idle(7);
        cap_in = 4'b0000; idle(7);
        for (int k = 16; k < 20; k++) rd(5'(k));
        for (int k = 16; k < 20; k++) rd(5'(k));   // R9 empty reads
        rd(15);

        // R8 overflow on channel 0
        for (int i = 0; i < 6; i++) begin
            cap_in[0] = 1'b1; idle(4);
            cap_in[0] = 1'b0; idle(4);
        end
        rd(15);
        for (int i = 0; i < 5; i++) rd(16);
        rd(15);
        wr(15, 16'h0001);                 // R8 clear
        rd(15);

        // R10 read sweep around a push on channel 2 (both edges)
        for (int off = 0; off < 6; off++) begin
            cap_in[2] = ~cap_in[2];
            idle(off);
            rd(18);
            idle(6);
            rd(18);
            rd(15);
        end
        // R10 with channel 2 full
        for (int i = 0; i < 4; i++) begin cap_in[2] = ~cap_in[2]; idle(5); end
        rd(15);
        for (int off = 0; off < 5; off++) begin
            cap_in[2] = ~cap_in[2];
            idle(off);
            rd(18);
            idle(6);
            rd(15);
        end
        for (int i = 0; i < 5; i++) rd(18);
        wr(15, 16'h000F);
        rd(15);

        // R1 R11 period change while running
        wr(0, 16'd4);
        idle(3); rd(24); idle(2); rd(24);
        wr(1, 16'd30);
        idle(20); rd(25); rd(25);
        idle(40);
        done();
    end
endmodule